// File: doc/BRIEF.md
# Multi-CPU Interrupt Controller Register Block

This block gathers interrupt requests for a small multi-processor system and presents one combined request line to each CPU. Two kinds of source feed it. The first is a set of level-sensitive device lines, which are synchronized and seen by every CPU. The second is a set of software mailbox bits, two per CPU, that any CPU can raise to signal another CPU. Each source has a raw pending state and an enable state. A CPU's request output is the OR of its enabled pending bits.

Software reaches the state through a 32-bit register bus inside a 4096-byte window. Every register group has three aliases: a plain form, a form that only sets bits, and a form that only clears bits. Single bits can therefore change without a read-modify-write sequence. Offset 0 holds a read-only count of the source bits. The spacing between groups is derived from that count. Each CPU has its own copy of the groups at a fixed address step. In the device word, that copy selects the CPU's private enable mask. The mailbox word is shared by all CPUs.

Top module: `mcpu_irq_ctrl`

## Requirements
- R1: The register at byte offset 0 of every CPU window reads as the source-bit count SRC_BITS, which is 32 plus two mailbox bits per CPU (40 at defaults). Writes to it have no effect.
- R2: Register groups start at byte offset 8 and are spaced STRIDE = 8*(1+(SRC_BITS-1)/64) bytes apart (8 at defaults). By group index 0..6 they are: raw, raw set-only, raw clear-only, source, enable, enable set-only, enable clear-only. Word 0 of a group (offset +0) holds the device bits and word 1 (offset +4) holds the mailbox bits. Every alias reads back the state of its group. Writes to the source group have no effect.
- R3: Writing a mask to a set-only alias sets exactly the bits that are 1 in the mask and leaves every other bit unchanged.
- R4: Writing a mask to a clear-only alias clears exactly the bits that are 1 in the mask and leaves every other bit unchanged.
- R5: Mailbox bit m of CPU c sits at bit index c*2+m of word 1. Mailbox raw and enable state is shared: a write through any CPU's window changes the same bits that every window reads.
- R6: Device raw bits 0..3 of word 0 follow the input lines through a two-flop synchronizer. A raw bit reads the new level two clock edges after the input changes. Writes to the raw aliases of word 0 leave these bits unchanged.
- R7: The source group reads as raw AND enable, for the window's own CPU in word 0 and for the shared mailbox state in word 1.
- R8: irq_out[c] is a register. It is set when CPU c has an enabled device bit or an enabled mailbox bit of its own pending. It changes one clock edge after the state that drives it changes.
- R9: The CPU window index sits in address bits [11:6], so each window is 64 bytes. Reads return 0 and writes have no effect when the address is misaligned, equals offset 4, or selects a CPU index of NUM_CPUS or more.
- R10: Reset clears all mailbox raw bits, all enable bits and all irq_out lines.
- R11: bus_rdata is registered. It shows the read result on the clock edge after a read request and is 0 in every cycle that follows no read.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| dev_irq | input | NUM_DEV | Level-sensitive device interrupt lines, asynchronous |
| bus_sel | input | 1 | Register access request for this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte address inside the window |
| bus_wdata | input | 32 | Write data or bit mask |
| bus_rdata | output | 32 | Registered read data |
| irq_out | output | NUM_CPUS | Combined interrupt request per CPU |

## Verification
The hardest condition to reach is a mailbox bit that is raised through one CPU's window, enabled through a second window and acknowledged through a third. This is the only way to show that the mailbox state is truly shared while the device enables stay private. The stimulus walks the mailbox bits through the windows of CPUs 0 to 3 in turn. It checks irq_out on the edge before and the edge after each change. For the device lines, it holds an input level and then fires raw write aliases at that bit. The raw value that reads back must stay with the line.

// File: rtl/mcpu_irq_pkg.sv
package mcpu_irq_pkg;

    typedef enum logic [2:0] {
        GRP_RAW     = 3'd0,
        GRP_RAW_SET = 3'd1,
        GRP_RAW_CLR = 3'd2,
        GRP_SRC     = 3'd3,
        GRP_EN      = 3'd4,
        GRP_EN_SET  = 3'd5,
        GRP_EN_CLR  = 3'd6
    } grp_e;

    typedef enum logic [1:0] {
        UPD_PLAIN = 2'd0,
        UPD_SET   = 2'd1,
        UPD_CLR   = 2'd2,
        UPD_NONE  = 2'd3
    } upd_e;

    localparam int CPU_FIELD_W = 8;

    typedef struct packed {
        logic                   hit_id;
        logic                   hit_reg;
        grp_e                   grp;
        logic                   word;
        logic [CPU_FIELD_W-1:0] cpu;
    } dec_t;

    function automatic upd_e upd_of(grp_e g);
        case (g)
            GRP_RAW, GRP_EN:         return UPD_PLAIN;
            GRP_RAW_SET, GRP_EN_SET: return UPD_SET;
            GRP_RAW_CLR, GRP_EN_CLR: return UPD_CLR;
            default:                 return UPD_NONE;
        endcase
    endfunction

    function automatic logic [31:0] apply_upd(logic [31:0] cur, logic [31:0] wd, upd_e u);
        case (u)
            UPD_PLAIN: return wd;
            UPD_SET:   return cur | wd;
            UPD_CLR:   return cur & ~wd;
            default:   return cur;
        endcase
    endfunction

    function automatic logic is_raw(grp_e g);
        return (g == GRP_RAW) || (g == GRP_RAW_SET) || (g == GRP_RAW_CLR);
    endfunction

endpackage

// File: rtl/mcpu_irq_sync.sv
module mcpu_irq_sync #(
    parameter int WIDTH  = 4,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_in,
    output logic [WIDTH-1:0] sync_out
);
    logic [STAGES-1:0][WIDTH-1:0] chain_q;

    for (genvar s = 0; s < STAGES; s++) begin : g_stage
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                chain_q[s] <= '0;
            end else if (s == 0) begin
                chain_q[s] <= async_in;
            end else begin
                chain_q[s] <= chain_q[(s > 0) ? s - 1 : 0];
            end
        end
    end

    assign sync_out = chain_q[STAGES-1];
endmodule

// File: rtl/mcpu_irq_decode.sv
module mcpu_irq_decode
    import mcpu_irq_pkg::*;
#(
    parameter int NUM_CPUS = 4,
    parameter int STRIDE   = 8,
    parameter int ADDR_W   = 12
) (
    input  logic [ADDR_W-1:0] addr,
    output dec_t              dec
);
    localparam int GRP_BASE = 8;
    localparam int SPAN     = GRP_BASE + 7 * STRIDE;
    localparam int LOC_W    = $clog2(SPAN);
    localparam int CPUF_W   = ADDR_W - LOC_W;

    logic [LOC_W-1:0]  loc;
    logic [CPUF_W-1:0] cpu_f;
    int unsigned       loc_i;
    int unsigned       gi;
    int unsigned       wi;
    logic              ok;

    assign loc   = addr[LOC_W-1:0];
    assign cpu_f = addr[ADDR_W-1:LOC_W];

    always_comb begin
        dec     = '0;
        loc_i   = 32'(loc);
        gi      = 0;
        wi      = 0;
        ok      = (addr[1:0] == 2'b00) && (32'(cpu_f) < 32'(NUM_CPUS));
        dec.cpu = CPU_FIELD_W'(cpu_f);
        if (ok && loc_i == 0) begin
            dec.hit_id = 1'b1;
        end else if (ok && loc_i >= 32'(GRP_BASE) && loc_i < 32'(SPAN)) begin
            gi = (loc_i - 32'(GRP_BASE)) / 32'(STRIDE);
            wi = ((loc_i - 32'(GRP_BASE)) % 32'(STRIDE)) / 4;
            if (wi < 2) begin
                dec.hit_reg = 1'b1;
                dec.grp     = grp_e'(gi[2:0]);
                dec.word    = wi[0];
            end
        end
    end
endmodule

// File: rtl/mcpu_irq_ctrl.sv
module mcpu_irq_ctrl
    import mcpu_irq_pkg::*;
#(
    parameter int NUM_CPUS     = 4,
    parameter int NUM_DEV      = 4,
    parameter int MBOX_PER_CPU = 2,
    parameter int SYNC_STAGES  = 2,
    parameter int ADDR_W       = 12
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NUM_DEV-1:0]  dev_irq,
    input  logic                bus_sel,
    input  logic                bus_wr,
    input  logic [ADDR_W-1:0]   bus_addr,
    input  logic [31:0]         bus_wdata,
    output logic [31:0]         bus_rdata,
    output logic [NUM_CPUS-1:0] irq_out
);
    localparam int MB_BITS  = NUM_CPUS * MBOX_PER_CPU;
    localparam int SRC_BITS = 32 + MB_BITS;
    localparam int STRIDE   = 8 * (1 + (SRC_BITS - 1) / 64);
    localparam int CPU_IW   = (NUM_CPUS > 1) ? $clog2(NUM_CPUS) : 1;

    typedef struct packed {
        logic [MB_BITS-1:0]               mb_raw;
        logic [MB_BITS-1:0]               mb_en;
        logic [NUM_CPUS-1:0][NUM_DEV-1:0] dev_en;
        logic [NUM_CPUS-1:0]              irq;
        logic [31:0]                      rdata;
    } state_t;

    state_t             st_d, st_q;
    dec_t               dec;
    logic [NUM_DEV-1:0] dev_raw;
    logic [CPU_IW-1:0]  cpu_sel;
    logic [31:0]        raw_w, en_w, rd_val;
    upd_e               upd;
    logic               wr_hit;

    mcpu_irq_sync #(.WIDTH(NUM_DEV), .STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .async_in(dev_irq), .sync_out(dev_raw)
    );

    mcpu_irq_decode #(.NUM_CPUS(NUM_CPUS), .STRIDE(STRIDE), .ADDR_W(ADDR_W)) u_dec (
        .addr(bus_addr), .dec(dec)
    );

    assign cpu_sel = dec.cpu[CPU_IW-1:0];
    assign wr_hit  = bus_sel && bus_wr && dec.hit_reg;

    always_comb begin
        st_d = st_q;
        upd  = upd_of(dec.grp);

        if (dec.word) begin
            raw_w = 32'(st_q.mb_raw);
            en_w  = 32'(st_q.mb_en);
        end else begin
            raw_w = 32'(dev_raw);
            en_w  = 32'(st_q.dev_en[cpu_sel]);
        end

        case (dec.grp)
            GRP_RAW, GRP_RAW_SET, GRP_RAW_CLR: rd_val = raw_w;
            GRP_SRC:                           rd_val = raw_w & en_w;
            GRP_EN, GRP_EN_SET, GRP_EN_CLR:    rd_val = en_w;
            default:                           rd_val = '0;
        endcase

        st_d.rdata = '0;
        if (bus_sel && !bus_wr) begin
            if (dec.hit_id)       st_d.rdata = 32'(SRC_BITS);
            else if (dec.hit_reg) st_d.rdata = rd_val;
        end

        if (wr_hit) begin
            if (dec.word) begin
                if (is_raw(dec.grp))
                    st_d.mb_raw = MB_BITS'(apply_upd(raw_w, bus_wdata, upd));
                else
                    st_d.mb_en = MB_BITS'(apply_upd(en_w, bus_wdata, upd));
            end else if (!is_raw(dec.grp)) begin
                st_d.dev_en[cpu_sel] = NUM_DEV'(apply_upd(en_w, bus_wdata, upd));
            end
        end

        for (int c = 0; c < NUM_CPUS; c++) begin
            st_d.irq[c] = (|(dev_raw & st_q.dev_en[c])) |
                (|(st_q.mb_raw[c*MBOX_PER_CPU +: MBOX_PER_CPU] &
                   st_q.mb_en[c*MBOX_PER_CPU +: MBOX_PER_CPU]));
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign bus_rdata = st_q.rdata;
    assign irq_out   = st_q.irq;

    // R3: a raw set-only write on the mailbox word leaves every masked bit at 1
    assert_raw_set_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_hit && dec.word && dec.grp == GRP_RAW_SET) |=>
        ((st_q.mb_raw & $past(bus_wdata[MB_BITS-1:0])) == $past(bus_wdata[MB_BITS-1:0])));

    // R4: a raw clear-only write on the mailbox word leaves every masked bit at 0
    assert_raw_clr_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_hit && dec.word && dec.grp == GRP_RAW_CLR) |=>
        ((st_q.mb_raw & $past(bus_wdata[MB_BITS-1:0])) == '0));

    // R8: with every enable bit clear, no request line is raised on the next edge
    assert_no_enable_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ((st_q.mb_en == '0) && (st_q.dev_en == '0)) |=> (irq_out == '0));

    // R11: read data stays zero after any cycle without a read request
    assert_rdata_idle_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_sel && !bus_wr) |=> (bus_rdata == '0));

    // R9: the decoder never reports the identification and a register group at once
    assert_dec_exclusive_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !(dec.hit_id && dec.hit_reg));
endmodule

// File: tb/mcpu_irq_ctrl_test.sv
module mcpu_irq_ctrl_test;
    localparam int CLK_PERIOD = 10;
    localparam int NCPU = 4;
    localparam int NDEV = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [NDEV-1:0] dev_irq = '0;
    logic        bus_sel = 1'b0;
    logic        bus_wr = 1'b0;
    logic [11:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [NCPU-1:0] irq_out;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;
    logic rd_issued = 1'b0;
    logic [31:0] exp_q[$];
    string       tag_q[$];

    mcpu_irq_ctrl uut (
        .clk(clk), .rst_n(rst_n), .dev_irq(dev_irq), .bus_sel(bus_sel),
        .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .irq_out(irq_out)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic logic [11:0] ra(int cpu, int grp, int word);
        return 12'(cpu * 64 + 8 + grp * 8 + word * 4);
    endfunction

    task automatic chk(logic [31:0] act, logic [31:0] exp, string tag);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=0x%08h expected=0x%08h", tag, act, exp);
        end
    endtask

    task automatic idle(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(logic [11:0] a, logic [31:0] d);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic rd(logic [11:0] a, logic [31:0] exp, string tag);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
        exp_q.push_back(exp);
        tag_q.push_back(tag);
        @(negedge clk);
        bus_sel = 1'b0;
    endtask

    // monitor: pops the scoreboard once per completed read
    always @(posedge clk) rd_issued <= bus_sel && !bus_wr;
    always @(negedge clk) begin
        if (rd_issued) begin
            if (exp_q.size() == 0) begin
                chk(bus_rdata, 32'hDEAD_BEEF, "R11 unexpected read result");
            end else begin
                chk(bus_rdata, exp_q.pop_front(), tag_q.pop_front());
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            fails++;
            checks++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        idle(3);
        rst_n = 1'b1;
        idle(1);
        // reset state
        chk(32'(irq_out), 32'h0, "R10 irq after reset");
        rd(12'h000, 32'd40, "R1 source count");
        rd(ra(0, 0, 1), 32'h0, "R10 mailbox raw after reset");
        rd(ra(0, 4, 0), 32'h0, "R10 device enable after reset");
        wr(12'h000, 32'd123);
        rd(12'h000, 32'd40, "R1 write ignored");

        // mailbox aliases across windows
        wr(ra(0, 1, 1), 32'h05);
        rd(ra(0, 0, 1), 32'h05, "R3 raw set");
        wr(ra(2, 1, 1), 32'h30);
        rd(ra(1, 1, 1), 32'h35, "R5 shared mailbox via set alias read");
        wr(ra(3, 2, 1), 32'h11);
        rd(ra(0, 0, 1), 32'h24, "R4 raw clear");
        chk(32'(irq_out), 32'h0, "R8 nothing enabled");
        wr(ra(0, 0, 1), 32'hFFFF_FF81);
        rd(ra(0, 0, 1), 32'h81, "R2 plain raw write");

        wr(ra(1, 5, 1), 32'h03);
        chk(32'(irq_out), 32'h0, "R8 registered latency");
        idle(1);
        chk(32'(irq_out), 32'h1, "R8 cpu0 mailbox");
        rd(ra(0, 3, 1), 32'h01, "R7 mailbox source");
        rd(ra(2, 4, 1), 32'h03, "R5 enable shared");
        wr(ra(0, 5, 1), 32'h80);
        idle(1);
        chk(32'(irq_out), 32'h9, "R8 cpu3 mailbox");
        wr(ra(0, 6, 1), 32'h01);
        idle(1);
        chk(32'(irq_out), 32'h8, "R4 enable clear");
        wr(ra(3, 2, 1), 32'h80);
        idle(1);
        chk(32'(irq_out), 32'h0, "R4 mailbox acknowledge");
        wr(ra(0, 3, 1), 32'hFF);
        rd(ra(0, 0, 1), 32'h01, "R2 source write ignored");

        // device lines
        wr(ra(1, 5, 0), 32'h4);
        dev_irq = 4'b0100;
        idle(1);
        rd(ra(0, 0, 0), 32'h0, "R6 raw before sync");
        chk(32'(irq_out), 32'h0, "R6 sync latency");
        idle(1);
        chk(32'(irq_out), 32'h2, "R8 cpu1 device");
        rd(ra(0, 0, 0), 32'h4, "R6 raw follows line");
        rd(ra(0, 3, 0), 32'h0, "R7 cpu0 device source");
        rd(ra(1, 3, 0), 32'h4, "R7 cpu1 device source");
        wr(ra(1, 2, 0), 32'hF);
        wr(ra(1, 0, 0), 32'h0);
        rd(ra(1, 0, 0), 32'h4, "R6 raw writes ignored");
        chk(32'(irq_out), 32'h2, "R6 irq held by line");
        dev_irq = 4'b0000;
        idle(3);
        chk(32'(irq_out), 32'h0, "R8 line dropped");
        wr(ra(3, 4, 0), 32'hFFFF_FFFF);
        rd(ra(3, 4, 0), 32'hF, "R2 device enable width");
        dev_irq = 4'b0010;
        idle(3);
        chk(32'(irq_out), 32'h8, "R8 cpu3 device");
        dev_irq = 4'b0000;

        // unmapped space
        rd(12'(4 * 64 + 8), 32'h0, "R9 cpu index out of range");
        wr(ra(4, 5, 1), 32'hFF);
        rd(ra(0, 4, 1), 32'h82, "R9 write to missing cpu ignored");
        rd(12'h004, 32'h0, "R9 offset 4");
        rd(12'h009, 32'h0, "R9 misaligned read");
        rd(12'hFF8, 32'h0, "R9 high address");
        wr(ra(0, 1, 1) + 12'd1, 32'h02);
        rd(ra(0, 0, 1), 32'h01, "R9 misaligned write ignored");
        idle(1);
        chk(bus_rdata, 32'h0, "R11 idle read data");

        // reset in the middle
        wr(ra(0, 1, 1), 32'hFF);
        rst_n = 1'b0;
        idle(2);
        rst_n = 1'b1;
        idle(1);
        chk(32'(irq_out), 32'h0, "R10 irq after second reset");
        rd(ra(0, 0, 1), 32'h0, "R10 mailbox raw cleared");
        rd(ra(0, 4, 1), 32'h0, "R10 mailbox enable cleared");
        rd(ra(3, 4, 0), 32'h0, "R10 device enable cleared");

        idle(3);
        if (exp_q.size() != 0) chk(32'(exp_q.size()), 32'h0, "R11 reads left unanswered");
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule